// File: doc/BRIEF.md
# Converter Clock and Acquisition Prescaler

This block takes one fast input clock and produces, without any derived clock, a one-cycle clock enable for the converter core together with a sample/hold window. The rate is set by two stages in series. A 4-bit prescale code passes the input clock straight through when it is zero. For any other value it divides by twice the code. After that, a halving bit optionally divides the result by two more. For example, a 150 MHz input with prescale code 6 and the halving bit clear gives a 12.5 MHz converter rate, which is one enable every 12 input cycles.

A start request arms the acquisition logic. On the next converter enable the sample window opens and stays open for a programmed number of converter periods, which is the 4-bit acquisition code plus one. When the window closes, the block issues a single-cycle conversion-start pulse. Prescale settings take effect only at a divider terminal count, so a reprogrammed rate never produces a shortened enable period.

Top module: `adc_acq_clkgen`

## Requirements
- R1: While reset is held, conv_ce, smp_win and conv_go are all low.
- R2: With prescale code 0 and the halving bit clear, conv_ce is high on every input clock cycle.
- R3: With prescale code c in 1..15 and the halving bit clear, conv_ce pulses once every 2*c input cycles.
- R4: Setting the halving bit doubles the conv_ce period for any prescale code, including code 0 (period 2).
- R5: Prescale code 6 with the halving bit clear gives a period of 12 input cycles, matching 150 MHz in and 12.5 MHz out.
- R6: A new prescale code takes effect only after the divider's current period ends. The enable interval during which the code changes keeps the old length, and the next interval uses the new length.
- R7: smp_win rises on the clock edge at which conv_ce is high, following a start_req seen while idle.
- R8: smp_win stays high for exactly (acq_len + 1) conv_ce periods, using the acq_len value sampled at the edge where the window opened.
- R9: conv_go is high for exactly one cycle, in the cycle in which smp_win has just fallen, and at no other time.
- R10: A start_req or an acq_len change that arrives while a request is pending or a window is open has no effect. The window length is unchanged and no extra window follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_code | input | 4 | First-stage prescale code: 0 passes through, c divides by 2*c |
| conv_half | input | 1 | Second-stage select: 1 divides the intermediate rate by two |
| acq_len | input | 4 | Acquisition code: the window lasts acq_len+1 converter periods |
| start_req | input | 1 | Request to start an acquisition, sampled while idle |
| conv_ce | output | 1 | Single-cycle converter clock enable |
| smp_win | output | 1 | Sample/hold acquisition window |
| conv_go | output | 1 | One-cycle conversion-start pulse after the window closes |

## Verification
The hardest case to reach from the ports is a prescale code that changes in the middle of a divider period. Its effect shows only in the length of the enable interval that straddles the change. To get there, the stimulus first synchronises to an observed enable, queues the old and new periods as expected items, and only then rewrites the code a few cycles into the running period. A related case is a start request and an acquisition-code change issued while a window is open. The bench checks that the window length still follows the latched code and that no second window appears afterwards.

// File: rtl/adc_ckgen_pkg.sv
package adc_ckgen_pkg;

   typedef enum logic [1:0] {
      ACQ_IDLE   = 2'd0,
      ACQ_ARMED  = 2'd1,
      ACQ_SAMPLE = 2'd2
   } acq_state_e;

endpackage

// File: rtl/ckg_pre_div.sv
module ckg_pre_div #(
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] pre_code,
   output logic             fclk_ce
);
   localparam int CNT_W = PRE_W + 1;

   logic [PRE_W-1:0] act_code;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;
   logic             at_end;

   // code 0 bypasses (terminal every cycle), else terminal after 2*code cycles
   always_comb begin
      if (act_code == '0) lim = '0;
      else                lim = ({1'b0, act_code} << 1) - CNT_W'(1);
   end

   assign at_end = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_code <= '0;
         cnt      <= '0;
         fclk_ce  <= 1'b0;
      end else if (at_end) begin
         cnt      <= '0;
         act_code <= pre_code;
         fclk_ce  <= 1'b1;
      end else begin
         cnt      <= cnt + CNT_W'(1);
         fclk_ce  <= 1'b0;
      end
   end
endmodule

// File: rtl/ckg_conv_div.sv
module ckg_conv_div (
   input  logic clk,
   input  logic rst_n,
   input  logic fclk_ce,
   input  logic half_sel,
   output logic conv_ce
);
   logic ph;
   logic act_half;

   assign conv_ce = fclk_ce & (~act_half | ph);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= 1'b0;
         act_half <= 1'b0;
      end else if (fclk_ce) begin
         if (conv_ce) begin
            ph       <= 1'b0;
            act_half <= half_sel;
         end else begin
            ph       <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ckg_acq_win.sv
module ckg_acq_win
   import adc_ckgen_pkg::*;
#(
   parameter int ACQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_ce,
   input  logic             start_req,
   input  logic [ACQ_W-1:0] acq_len,
   output logic             smp_win,
   output logic             conv_go
);
   acq_state_e       state;
   logic [ACQ_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ACQ_IDLE;
         left    <= '0;
         smp_win <= 1'b0;
         conv_go <= 1'b0;
      end else begin
         conv_go <= 1'b0;
         case (state)
            ACQ_IDLE: begin
               if (start_req) state <= ACQ_ARMED;
            end
            ACQ_ARMED: begin
               if (conv_ce) begin
                  state   <= ACQ_SAMPLE;
                  smp_win <= 1'b1;
                  left    <= acq_len;
               end
            end
            ACQ_SAMPLE: begin
               if (conv_ce) begin
                  if (left == '0) begin
                     smp_win <= 1'b0;
                     conv_go <= 1'b1;
                     state   <= ACQ_IDLE;
                  end else begin
                     left <= left - ACQ_W'(1);
                  end
               end
            end
            default: state <= ACQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_acq_clkgen.sv
module adc_acq_clkgen #(
   parameter int PRE_W = 4,
   parameter int ACQ_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] pre_code,
   input  logic             conv_half,
   input  logic [ACQ_W-1:0] acq_len,
   input  logic             start_req,
   output logic             conv_ce,
   output logic             smp_win,
   output logic             conv_go
);
   if (PRE_W < 1 || PRE_W > 8) begin : g_bad_pre_w
      $error("PRE_W must lie in 1..8");
   end
   if (ACQ_W < 1 || ACQ_W > 8) begin : g_bad_acq_w
      $error("ACQ_W must lie in 1..8");
   end

   logic fclk_ce;

   ckg_pre_div #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .pre_code (pre_code),
      .fclk_ce  (fclk_ce)
   );

   ckg_conv_div u_cdiv (
      .clk      (clk),
      .rst_n    (rst_n),
      .fclk_ce  (fclk_ce),
      .half_sel (conv_half),
      .conv_ce  (conv_ce)
   );

   ckg_acq_win #(.ACQ_W(ACQ_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_ce   (conv_ce),
      .start_req (start_req),
      .acq_len   (acq_len),
      .smp_win   (smp_win),
      .conv_go   (conv_go)
   );
endmodule

// File: rtl/adc_acq_clkgen_chk.sv
module adc_acq_clkgen_chk #(
   parameter int ACQ_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_ce,
   input logic             smp_win,
   input logic             conv_go,
   input logic [ACQ_W-1:0] acq_len
);
   logic [ACQ_W:0]   ce_seen;
   logic [ACQ_W-1:0] acq_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_seen  <= '0;
         acq_hold <= '0;
      end else begin
         if (!smp_win) begin
            acq_hold <= acq_len;
            ce_seen  <= '0;
         end else if (conv_ce) begin
            ce_seen  <= ce_seen + (ACQ_W+1)'(1);
         end
      end
   end

   // R7
   win_rise_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(smp_win) |-> $past(conv_ce));

   // R8
   win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_win && conv_ce && ce_seen == {1'b0, acq_hold}) |=> !smp_win);

   // R8
   win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_win && !(conv_ce && ce_seen == {1'b0, acq_hold})) |=> smp_win);

   // R9
   go_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smp_win) |-> conv_go);

   // R9
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_go |=> !conv_go);

   // R9
   go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_go |-> $fell(smp_win));
endmodule

bind adc_acq_clkgen adc_acq_clkgen_chk #(.ACQ_W(ACQ_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .conv_ce (conv_ce),
   .smp_win (smp_win),
   .conv_go (conv_go),
   .acq_len (acq_len)
);

// File: tb/adc_acq_clkgen_bench.sv
module adc_acq_clkgen_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      int    val;
      string tag;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pre_code = 4'd6;
   logic       conv_half = 1'b0;
   logic [3:0] acq_len = 4'd0;
   logic       start_req = 1'b0;
   logic       conv_ce;
   logic       smp_win;
   logic       conv_go;

   int checks = 0;
   int fails  = 0;

   exp_item_t ce_q[$];
   exp_item_t win_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_acq_clkgen u_adc_acq_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .pre_code  (pre_code),
      .conv_half (conv_half),
      .acq_len   (acq_len),
      .start_req (start_req),
      .conv_ce   (conv_ce),
      .smp_win   (smp_win),
      .conv_go   (conv_go)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int period_of(input int c, input bit h);
      return (c == 0 ? 1 : 2 * c) * (h ? 2 : 1);
   endfunction

   // enable-period monitor
   int  cyc = 0;
   int  last_ce = 0;
   bit  have_last = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (conv_ce) begin
            if (have_last && ce_q.size() > 0) begin
               exp_item_t it;
               it = ce_q.pop_front();
               check(cyc - last_ce == it.val, it.tag, cyc - last_ce, it.val);
            end
            last_ce   = cyc;
            have_last = 1;
         end
      end
   end

   // window monitor
   bit win_prev = 0;
   bit ce_prev  = 0;
   int win_cnt  = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (smp_win && !win_prev) begin
            check(ce_prev == 1'b1, "R7 window opens on enable", ce_prev, 1);
            win_cnt = 1;
         end else if (smp_win) begin
            win_cnt++;
         end
         if (!smp_win && win_prev) begin
            check(conv_go == 1'b1, "R9 conv_go at window close", conv_go, 1);
            if (win_q.size() > 0) begin
               exp_item_t it;
               it = win_q.pop_front();
               check(win_cnt == it.val, it.tag, win_cnt, it.val);
            end else begin
               check(1'b0, "R10 unexpected window", win_cnt, 0);
            end
         end else if (conv_go) begin
            check(1'b0, "R9 stray conv_go", 1, 0);
         end
         win_prev = smp_win;
         ce_prev  = conv_ce;
      end
   end

   task automatic wait_ce();
      do @(negedge clk); while (!conv_ce);
      #1;
   endtask

   task automatic set_clk(input int c, input bit h);
      @(negedge clk); #1;
      pre_code  = 4'(c);
      conv_half = h;
      repeat (4) wait_ce();
   endtask

   task automatic measure(input int c, input bit h, input string tag);
      exp_item_t it;
      set_clk(c, h);
      it.val = period_of(c, h);
      it.tag = tag;
      ce_q.push_back(it);
      ce_q.push_back(it);
      while (ce_q.size() != 0) @(negedge clk);
   endtask

   task automatic pulse_start();
      @(negedge clk); #1;
      start_req = 1'b1;
      @(negedge clk); #1;
      start_req = 1'b0;
   endtask

   task automatic run_window(input int acq, input int per, input string tag);
      exp_item_t it;
      @(negedge clk); #1;
      acq_len = 4'(acq);
      it.val = (acq + 1) * per;
      it.tag = tag;
      win_q.push_back(it);
      pulse_start();
      while (win_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(conv_ce == 0 && smp_win == 0 && conv_go == 0, "R1 reset outputs",
            {conv_ce, smp_win, conv_go}, 0);
      #1 rst_n = 1'b1;

      measure(6, 0, "R5 code 6 period");
      measure(0, 0, "R2 bypass period");
      measure(1, 0, "R3 code 1 period");
      measure(15, 0, "R3 code 15 period");
      measure(3, 0, "R3 code 3 period");
      measure(3, 1, "R4 halved code 3 period");
      measure(0, 1, "R4 halved bypass period");
      measure(15, 1, "R4 halved code 15 period");

      // R6 code changed mid-period: old length first, new after
      begin
         exp_item_t a, b;
         set_clk(6, 0);
         wait_ce();
         a.val = 12; a.tag = "R6 straddling interval";
         b.val = 4;  b.tag = "R6 new interval";
         ce_q.push_back(a);
         ce_q.push_back(b);
         repeat (3) @(negedge clk);
         #1 pre_code = 4'd2;
         while (ce_q.size() != 0) @(negedge clk);
      end

      set_clk(2, 0);
      run_window(0, 4, "R8 window acq 0");
      run_window(7, 4, "R8 window acq 7");
      run_window(15, 4, "R8 window acq 15");
      set_clk(0, 0);
      run_window(2, 1, "R8 window acq 2 bypass");
      set_clk(5, 1);
      run_window(1, 20, "R8 window acq 1 halved");

      // R10 start and acq change during open window are ignored
      set_clk(2, 0);
      begin
         exp_item_t it;
         bit extra;
         @(negedge clk); #1;
         acq_len = 4'd3;
         it.val = 16; it.tag = "R10 window length kept";
         win_q.push_back(it);
         pulse_start();
         while (!smp_win) @(negedge clk);
         repeat (3) @(negedge clk);
         #1 acq_len = 4'd9;
         pulse_start();
         while (win_q.size() != 0) @(negedge clk);
         extra = 0;
         repeat (40) begin
            @(negedge clk);
            if (smp_win) extra = 1;
         end
         check(extra == 0, "R10 no extra window", extra, 0);
      end

      check(ce_q.size() == 0 && win_q.size() == 0, "R8 all expected items seen",
            ce_q.size() + win_q.size(), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule